// File: doc/BRIEF.md
# Histogram Snapshot Readout Controller

This controller connects a set of histogram instances in a streaming clock domain to a memory-mapped host in a separate clock domain. The host never reads the live bin memories. Instead, it writes an instance number into a selection register and then writes a start command. The controller reads every bin of the chosen instance's idle page, one address per data-path cycle, and stores the words in a dual-clock snapshot buffer. The host polls a busy bit until it clears, then reads the bins from the buffer through a simple read port with a read-valid strobe.

Each histogram instance owns two pages and swaps them on its input sync. Every instance receives the same source address and read strobe, and each returns the word from its idle page one data-path cycle later. The controller picks the returned lane that matches the instance it latched at start. A copy lasts only a few cycles more than the bin count, so it can finish inside one sync period.

The data-path sequencer has three states. SQ_IDLE waits for a start event and moves to SQ_READ when one arrives. SQ_READ issues one source read per cycle and moves to SQ_DRAIN once the last bin address has been issued. SQ_DRAIN writes the final word, sends the completion toggle back to the host side and returns to SQ_IDLE.

Top module: `hist_snap_ctrl`

## Requirements
- R1: Register address 1 holds the instance index, INST_W = ceil(log2(N_INST)) bits wide, taken from the low bits of the written word. Reading address 1 returns it zero-extended.
- R2: A write to register address 2 with bit 0 set starts a copy when the controller is idle. A write to address 2 with bit 0 clear starts nothing.
- R3: Bit 0 of register address 2 is the busy flag. It reads 0 after reset, is 1 from the cycle after an accepted start, and returns to 0 only after the last bin has been written into the buffer.
- R4: A copy transfers all N_BINS bins of the selected instance's idle page. Bin b lands at buffer address b, and source data is taken one data-path cycle after its read strobe.
- R5: A buffer read at address b returns the stored word in the following host cycle, with buf_rvalid high for exactly that cycle.
- R6: Bin words are BIN_W = ceil(log2(SAMPLES_PER_SYNC)) + 1 bits wide, and the full range from 0 to 2^BIN_W - 1 is kept unchanged.
- R7: A copy issues exactly N_BINS consecutive source reads, at addresses 0 to N_BINS-1, and then stops reading.
- R8: The instance index is captured at start. Rewriting address 1 during a copy does not change which instance is copied.
- R9: A start command written while the busy flag is 1 is ignored. It neither restarts nor extends the running copy.
- R10: A register read returns data with reg_rvalid in the following host cycle. Unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dp_clk | input | 1 | Data-path clock |
| dp_rst | input | 1 | Data-path reset, active high |
| host_clk | input | 1 | Host clock |
| host_rst | input | 1 | Host reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | REG_AW | Register address |
| reg_wdata | input | REG_DW | Register write data |
| reg_rdata | output | REG_DW | Register read data |
| reg_rvalid | output | 1 | Register read data valid |
| buf_rd | input | 1 | Snapshot buffer read strobe |
| buf_addr | input | BIN_AW | Snapshot buffer bin address |
| buf_rdata | output | BIN_W | Snapshot buffer read data |
| buf_rvalid | output | 1 | Snapshot buffer read data valid |
| src_rd | output | 1 | Read strobe to every histogram instance |
| src_addr | output | BIN_AW | Bin address to every histogram instance |
| src_rdata | input | N_INST*BIN_W | Idle-page words from every instance, lane i for instance i |

## Verification
The bench builds the controller with four instances, sixteen bins and 64 samples per sync, which gives 7-bit bin words. With these values, an index write of 7 checks that the register truncates to 2 bits. The top bin of every page holds the maximum 7-bit value. The two clocks have unrelated 10 ns and 14 ns periods, so the start and completion signals really do cross between asynchronous domains. Copies of different instances, taken before and after a page swap, show that the correct lane and the idle page are copied. Index changes and start commands written during a copy exercise the latching and the ignore rules.

// File: rtl/hsc_pkg.sv
package hsc_pkg;
    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_READ,
        SQ_DRAIN
    } sq_state_t;

    localparam int ADDR_SEL = 1;
    localparam int ADDR_CTL = 2;
endpackage

// File: rtl/hsc_regs.sv
module hsc_regs #(
    parameter int INST_W = 2,
    parameter int REG_AW = 2,
    parameter int REG_DW = 32
) (
    input  logic              host_clk,
    input  logic              host_rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    output logic              reg_rvalid,
    input  logic              done_tgl,
    output logic              start_tgl,
    output logic [INST_W-1:0] sel_snap,
    output logic              filling
);
    import hsc_pkg::*;

    logic [INST_W-1:0] sel_reg;
    logic              wr_sel;
    logic              wr_go;
    logic [2:0]        done_sync;
    logic              done_evt;
    logic              unused_wdata;

    assign unused_wdata = &{1'b0, reg_wdata};

    assign wr_sel   = reg_wr && (reg_addr == REG_AW'(ADDR_SEL));
    assign wr_go    = reg_wr && (reg_addr == REG_AW'(ADDR_CTL)) && reg_wdata[0] && !filling;
    assign done_evt = done_sync[1] ^ done_sync[2];

    always_ff @(posedge host_clk or posedge host_rst) begin
        if (host_rst) begin
            sel_reg   <= '0;
            sel_snap  <= '0;
            start_tgl <= 1'b0;
            filling   <= 1'b0;
            done_sync <= '0;
        end else begin
            done_sync <= {done_sync[1:0], done_tgl};
            if (wr_sel) begin
                sel_reg <= reg_wdata[INST_W-1:0];
            end
            if (wr_go) begin
                start_tgl <= ~start_tgl;
                sel_snap  <= sel_reg;
                filling   <= 1'b1;
            end else if (done_evt) begin
                filling   <= 1'b0;
            end
        end
    end

    always_ff @(posedge host_clk or posedge host_rst) begin
        if (host_rst) begin
            reg_rdata  <= '0;
            reg_rvalid <= 1'b0;
        end else begin
            reg_rvalid <= reg_rd;
            reg_rdata  <= '0;
            if (reg_rd) begin
                if (reg_addr == REG_AW'(ADDR_SEL)) begin
                    reg_rdata <= REG_DW'(sel_reg);
                end else if (reg_addr == REG_AW'(ADDR_CTL)) begin
                    reg_rdata <= REG_DW'(filling);
                end
            end
        end
    end
endmodule

// File: rtl/hsc_seq.sv
module hsc_seq #(
    parameter int N_INST = 4,
    parameter int N_BINS = 16,
    parameter int BIN_W  = 7,
    parameter int INST_W = 2,
    parameter int BIN_AW = 4
) (
    input  logic                    dp_clk,
    input  logic                    dp_rst,
    input  logic                    start_tgl,
    input  logic [INST_W-1:0]       sel_snap,
    input  logic [N_INST*BIN_W-1:0] src_rdata,
    output logic                    src_rd,
    output logic [BIN_AW-1:0]       src_addr,
    output logic                    buf_we,
    output logic [BIN_AW-1:0]       buf_waddr,
    output logic [BIN_W-1:0]        buf_wdata,
    output logic [INST_W-1:0]       cur_inst,
    output logic                    done_tgl
);
    import hsc_pkg::*;

    localparam logic [BIN_AW-1:0] LAST_ADDR = BIN_AW'(N_BINS - 1);

    sq_state_t  state, nxt_state;
    logic [2:0] start_sync;
    logic       start_evt;
    logic       finish;

    assign start_evt = start_sync[1] ^ start_sync[2];

    always_comb begin
        nxt_state = state;
        unique case (state)
            SQ_IDLE:  if (start_evt) nxt_state = SQ_READ;
            SQ_READ:  if (src_addr == LAST_ADDR) nxt_state = SQ_DRAIN;
            SQ_DRAIN: nxt_state = SQ_IDLE;
            default:  nxt_state = SQ_IDLE;
        endcase
    end

    always_ff @(posedge dp_clk or posedge dp_rst) begin
        if (dp_rst) state <= SQ_IDLE;
        else        state <= nxt_state;
    end

    always_comb begin
        src_rd = 1'b0;
        finish = 1'b0;
        unique case (state)
            SQ_IDLE:  ;
            SQ_READ:  src_rd = 1'b1;
            SQ_DRAIN: finish = 1'b1;
            default:  ;
        endcase
    end

    always_ff @(posedge dp_clk or posedge dp_rst) begin
        if (dp_rst) begin
            start_sync <= '0;
            src_addr   <= '0;
            cur_inst   <= '0;
            buf_we     <= 1'b0;
            buf_waddr  <= '0;
            done_tgl   <= 1'b0;
        end else begin
            start_sync <= {start_sync[1:0], start_tgl};
            if (state == SQ_IDLE) begin
                src_addr <= '0;
                if (start_evt) cur_inst <= sel_snap;
            end else if (src_rd) begin
                src_addr <= src_addr + 1'b1;
            end
            buf_we    <= src_rd;
            buf_waddr <= src_addr;
            if (finish) done_tgl <= ~done_tgl;
        end
    end

    assign buf_wdata = src_rdata[cur_inst*BIN_W +: BIN_W];
endmodule

// File: rtl/hsc_buf.sv
module hsc_buf #(
    parameter int DEPTH = 16,
    parameter int W     = 7,
    parameter int AW    = 4
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic          rclk,
    input  logic          rrst,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata,
    output logic          rvalid
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_ff @(posedge rclk) begin
        if (re) rdata <= mem[raddr];
    end

    always_ff @(posedge rclk or posedge rrst) begin
        if (rrst) rvalid <= 1'b0;
        else      rvalid <= re;
    end
endmodule

// File: rtl/hist_snap_ctrl.sv
module hist_snap_ctrl #(
    parameter int N_INST           = 4,
    parameter int N_BINS           = 16,
    parameter int SAMPLES_PER_SYNC = 64,
    parameter int REG_AW           = 2,
    parameter int REG_DW           = 32,
    localparam int BIN_W  = $clog2(SAMPLES_PER_SYNC) + 1,
    localparam int BIN_AW = (N_BINS > 1) ? $clog2(N_BINS) : 1,
    localparam int INST_W = (N_INST > 1) ? $clog2(N_INST) : 1
) (
    input  logic                    dp_clk,
    input  logic                    dp_rst,
    input  logic                    host_clk,
    input  logic                    host_rst,
    input  logic                    reg_wr,
    input  logic                    reg_rd,
    input  logic [REG_AW-1:0]       reg_addr,
    input  logic [REG_DW-1:0]       reg_wdata,
    output logic [REG_DW-1:0]       reg_rdata,
    output logic                    reg_rvalid,
    input  logic                    buf_rd,
    input  logic [BIN_AW-1:0]       buf_addr,
    output logic [BIN_W-1:0]        buf_rdata,
    output logic                    buf_rvalid,
    output logic                    src_rd,
    output logic [BIN_AW-1:0]       src_addr,
    input  logic [N_INST*BIN_W-1:0] src_rdata
);
    logic              start_tgl;
    logic              done_tgl;
    logic              filling;
    logic [INST_W-1:0] sel_snap;
    logic [INST_W-1:0] seq_inst;
    logic              wr_en;
    logic [BIN_AW-1:0] wr_addr;
    logic [BIN_W-1:0]  wr_data;

    hsc_regs #(
        .INST_W (INST_W),
        .REG_AW (REG_AW),
        .REG_DW (REG_DW)
    ) u_regs (
        .host_clk   (host_clk),
        .host_rst   (host_rst),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .reg_rvalid (reg_rvalid),
        .done_tgl   (done_tgl),
        .start_tgl  (start_tgl),
        .sel_snap   (sel_snap),
        .filling    (filling)
    );

    hsc_seq #(
        .N_INST (N_INST),
        .N_BINS (N_BINS),
        .BIN_W  (BIN_W),
        .INST_W (INST_W),
        .BIN_AW (BIN_AW)
    ) u_seq (
        .dp_clk    (dp_clk),
        .dp_rst    (dp_rst),
        .start_tgl (start_tgl),
        .sel_snap  (sel_snap),
        .src_rdata (src_rdata),
        .src_rd    (src_rd),
        .src_addr  (src_addr),
        .buf_we    (wr_en),
        .buf_waddr (wr_addr),
        .buf_wdata (wr_data),
        .cur_inst  (seq_inst),
        .done_tgl  (done_tgl)
    );

    hsc_buf #(
        .DEPTH (N_BINS),
        .W     (BIN_W),
        .AW    (BIN_AW)
    ) u_buf (
        .wclk   (dp_clk),
        .we     (wr_en),
        .waddr  (wr_addr),
        .wdata  (wr_data),
        .rclk   (host_clk),
        .rrst   (host_rst),
        .re     (buf_rd),
        .raddr  (buf_addr),
        .rdata  (buf_rdata),
        .rvalid (buf_rvalid)
    );
endmodule

// File: rtl/hsc_chk.sv
module hsc_chk #(
    parameter int N_BINS = 16,
    parameter int BIN_AW = 4,
    parameter int INST_W = 2,
    parameter int REG_AW = 2,
    parameter int REG_DW = 32
) (
    input logic              dp_clk,
    input logic              dp_rst,
    input logic              host_clk,
    input logic              host_rst,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [REG_AW-1:0] reg_addr,
    input logic [REG_DW-1:0] reg_wdata,
    input logic              reg_rvalid,
    input logic              buf_rd,
    input logic              buf_rvalid,
    input logic              src_rd,
    input logic [BIN_AW-1:0] src_addr,
    input logic              filling,
    input logic [INST_W-1:0] seq_inst
);
    localparam logic [BIN_AW-1:0] LAST_ADDR = BIN_AW'(N_BINS - 1);

    AST_REG_RVALID: assert property (@(posedge host_clk) disable iff (host_rst)
        reg_rd |=> reg_rvalid); // R10

    AST_BUF_RVALID: assert property (@(posedge host_clk) disable iff (host_rst)
        buf_rd |=> buf_rvalid); // R5

    AST_BUSY_ON_START: assert property (@(posedge host_clk) disable iff (host_rst)
        (reg_wr && reg_addr == REG_AW'(2) && reg_wdata[0] && !filling) |=> filling); // R3

    AST_SRC_ADDR_STEP: assert property (@(posedge dp_clk) disable iff (dp_rst)
        (src_rd && src_addr != LAST_ADDR) |=> (src_rd && src_addr == BIN_AW'($past(src_addr) + 1'b1))); // R4

    AST_SRC_STOPS: assert property (@(posedge dp_clk) disable iff (dp_rst)
        (src_rd && src_addr == LAST_ADDR) |=> !src_rd); // R7

    AST_INST_STABLE: assert property (@(posedge dp_clk) disable iff (dp_rst)
        (src_rd && $past(src_rd)) |-> $stable(seq_inst)); // R8
endmodule

bind hist_snap_ctrl hsc_chk #(
    .N_BINS (N_BINS),
    .BIN_AW (BIN_AW),
    .INST_W (INST_W),
    .REG_AW (REG_AW),
    .REG_DW (REG_DW)
) u_chk (
    .dp_clk     (dp_clk),
    .dp_rst     (dp_rst),
    .host_clk   (host_clk),
    .host_rst   (host_rst),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rvalid (reg_rvalid),
    .buf_rd     (buf_rd),
    .buf_rvalid (buf_rvalid),
    .src_rd     (src_rd),
    .src_addr   (src_addr),
    .filling    (filling),
    .seq_inst   (seq_inst)
);

// File: tb/tb_hist_snap_ctrl.sv
module tb_hist_snap_ctrl;
    localparam int N_INST = 4;
    localparam int N_BINS = 16;
    localparam int SPS    = 64;
    localparam int BIN_W  = 7;
    localparam int BIN_AW = 4;
    localparam int DW     = 32;

    logic dp_clk = 1'b0;
    logic host_clk = 1'b0;
    logic dp_rst = 1'b1;
    logic host_rst = 1'b1;
    always #5 dp_clk = ~dp_clk;
    always #7 host_clk = ~host_clk;

    logic                    reg_wr = 1'b0;
    logic                    reg_rd = 1'b0;
    logic [1:0]              reg_addr = '0;
    logic [DW-1:0]           reg_wdata = '0;
    logic [DW-1:0]           reg_rdata;
    logic                    reg_rvalid;
    logic                    buf_rd = 1'b0;
    logic [BIN_AW-1:0]       buf_addr = '0;
    logic [BIN_W-1:0]        buf_rdata;
    logic                    buf_rvalid;
    logic                    src_rd;
    logic [BIN_AW-1:0]       src_addr;
    logic [N_INST*BIN_W-1:0] src_rdata = '0;

    hist_snap_ctrl #(
        .N_INST (N_INST), .N_BINS (N_BINS), .SAMPLES_PER_SYNC (SPS),
        .REG_AW (2), .REG_DW (DW)
    ) dut (
        .dp_clk (dp_clk), .dp_rst (dp_rst), .host_clk (host_clk), .host_rst (host_rst),
        .reg_wr (reg_wr), .reg_rd (reg_rd), .reg_addr (reg_addr), .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata), .reg_rvalid (reg_rvalid),
        .buf_rd (buf_rd), .buf_addr (buf_addr), .buf_rdata (buf_rdata), .buf_rvalid (buf_rvalid),
        .src_rd (src_rd), .src_addr (src_addr), .src_rdata (src_rdata)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural histogram pages: two per instance, idle page = !act
    logic [BIN_W-1:0] pg [N_INST][2][N_BINS];
    logic             act = 1'b0;

    function automatic logic [BIN_W-1:0] pval(int i, int p, int b, int s);
        if (b == N_BINS - 1) return 7'h7f;
        if (b == 0) return 7'h00;
        return BIN_W'((i * 29 + p * 61 + b * 13 + s * 7) % 127);
    endfunction

    task automatic load_pages(input int s);
        for (int i = 0; i < N_INST; i++)
            for (int p = 0; p < 2; p++)
                for (int b = 0; b < N_BINS; b++)
                    pg[i][p][b] = pval(i, p, b, s);
    endtask

    always @(posedge dp_clk) begin
        if (src_rd)
            for (int i = 0; i < N_INST; i++)
                src_rdata[i*BIN_W +: BIN_W] <= pg[i][int'(!act)][src_addr];
    end

    // cycle-by-cycle reference of the host read ports
    logic [BIN_W-1:0] exp_buf [N_BINS];
    logic             mdl_bv = 1'b0;
    logic [BIN_W-1:0] mdl_bd = '0;
    logic             mdl_rv = 1'b0;

    always @(posedge host_clk) begin
        mdl_bv <= buf_rd;
        mdl_bd <= exp_buf[buf_addr];
        mdl_rv <= reg_rd;
    end

    always @(negedge host_clk) begin
        if (!host_rst) begin
            if (mdl_bv || buf_rvalid)
                check(buf_rvalid == mdl_bv, "R5 buf_rvalid", buf_rvalid, mdl_bv);
            if (mdl_bv && buf_rvalid)
                check(buf_rdata == mdl_bd, "R4/R6 buffer word", buf_rdata, mdl_bd);
            if (mdl_rv || reg_rvalid)
                check(reg_rvalid == mdl_rv, "R10 reg_rvalid", reg_rvalid, mdl_rv);
        end
    end

    task automatic reg_write(input int a, input int d);
        @(negedge host_clk);
        reg_wr = 1'b1; reg_addr = 2'(a); reg_wdata = DW'(d);
        @(negedge host_clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input int a, output int d);
        @(negedge host_clk);
        reg_rd = 1'b1; reg_addr = 2'(a);
        @(negedge host_clk);
        reg_rd = 1'b0;
        d = int'(reg_rdata);
    endtask

    task automatic wait_idle(input string tag);
        int v;
        int n;
        n = 0;
        v = 1;
        while (v[0] && n < 200) begin
            reg_read(2, v);
            n++;
        end
        check(v[0] == 1'b0, tag, v, 0);
    endtask

    task automatic read_buffer();
        for (int b = 0; b < N_BINS; b++) begin
            @(negedge host_clk);
            buf_rd = 1'b1; buf_addr = BIN_AW'(b);
        end
        @(negedge host_clk);
        buf_rd = 1'b0;
        @(negedge host_clk);
    endtask

    task automatic set_expect(input int inst);
        for (int b = 0; b < N_BINS; b++) exp_buf[b] = pg[inst][int'(!act)][b];
    endtask

    task automatic copy_inst(input int inst, input string tag);
        int v;
        reg_write(1, inst);
        set_expect(inst);
        reg_write(2, 1);
        reg_read(2, v);
        check(v == 1, {tag, " R3 busy after start"}, v, 1);
        wait_idle({tag, " R3 busy clears"});
        read_buffer();
    endtask

    initial begin
        int v;
        load_pages(1);
        for (int b = 0; b < N_BINS; b++) exp_buf[b] = '0;
        repeat (4) @(posedge host_clk);
        dp_rst = 1'b0;
        host_rst = 1'b0;
        repeat (3) @(negedge host_clk);

        // reset state
        check(reg_rvalid == 1'b0, "R10 reset rvalid", reg_rvalid, 0);
        check(buf_rvalid == 1'b0, "R5 reset buf_rvalid", buf_rvalid, 0);
        reg_read(2, v);
        check(v == 0, "R3 reset busy", v, 0);

        // R1 select register and truncation
        reg_write(1, 2);
        reg_read(1, v);
        check(v == 2, "R1 select readback", v, 2);
        reg_write(1, 7);
        reg_read(1, v);
        check(v == 3, "R1 select truncated to 2 bits", v, 3);
        reg_read(3, v);
        check(v == 0, "R10 unmapped reads zero", v, 0);

        // copies of several lanes, idle page 1
        copy_inst(0, "inst0");
        copy_inst(3, "inst3");

        // page swap: idle page becomes 0
        act = 1'b1;
        copy_inst(0, "inst0 swapped");

        // R8 and R9: change index and restart during a copy
        reg_write(1, 1);
        set_expect(1);
        reg_write(2, 1);
        reg_write(1, 2);
        reg_write(2, 1);
        reg_read(2, v);
        check(v == 1, "R9 still busy after ignored start", v, 1);
        wait_idle("R3 busy clears after R8 test");
        repeat (60) @(negedge host_clk);
        reg_read(2, v);
        check(v == 0, "R9 no second copy", v, 0);
        read_buffer();

        // R2 write with bit0 clear starts nothing
        reg_write(2, 0);
        reg_read(2, v);
        check(v == 0, "R2 zero write leaves idle", v, 0);
        act = 1'b0;
        repeat (60) @(negedge host_clk);
        read_buffer();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge dp_clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired: actual hang expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule